// File: doc/BRIEF.md
# Microcontroller Branch Target Calculator

This unit works out where an 8-bit microcontroller goes next after a control-flow instruction. The decoder hands it a branch kind code and the address of the next sequential instruction. It also supplies the operand bytes, the accumulator, the data pointer and the condition inputs: carry, the addressed bit, the two compare operands and the loop counter value. The unit returns the next program counter and a taken flag. It also returns the side effects that the sequencer must commit: a carry write for compare-and-branch, a bit clear for the test-and-clear branch, and a decremented counter for the loop branch.

Four address forms are supported:
- A page-absolute form keeps the upper five bits of the next-instruction address and splices in an 11-bit field.
- A long form carries a full 16-bit target.
- A relative form adds a signed 8-bit offset to the next-instruction address.
- An indirect form adds the accumulator to the data pointer.

All address arithmetic wraps modulo 65536. With the default `REG_OUT=1`, results are registered and appear one cycle after a valid request. With `REG_OUT=0` the output stage is a plain bypass.

Top module: `flow_target_unit`

## Requirements
- R1: Kind 1 (page-absolute) is always taken. `target_pc` = {`seq_pc`[15:11], `page_sel`[2:0], `opa`[7:0]}.
- R2: Kind 2 (long) is always taken. `target_pc` = {`opa`, `opb`}, with `opa` as the high byte.
- R3: Kind 3 (relative, unconditional) is always taken. `target_pc` = `seq_pc` + sign-extended `rel_off`, modulo 65536.
- R4: Kind 4 (indirect) is always taken. `target_pc` = `dptr` + zero-extended `acc`, modulo 65536.
- R5: Kinds 5, 6, 7 and 8 take the relative target under these conditions:
  - kind 5 when `carry_in`=1;
  - kind 6 when `carry_in`=0;
  - kind 7 when `acc`==0;
  - kind 8 when `acc`!=0.
- R6: Kind 9 is taken when `bit_in`=1 and kind 10 when `bit_in`=0. In both cases `bit_clr` stays 0.
- R7: Kind 11 is taken when `bit_in`=1, and `bit_clr` is 1 exactly when it is taken.
- R8: Kind 12 is taken when `cmp_lhs` != `cmp_rhs`.
  - It asserts `carry_wr`, with `carry_val` = (`cmp_lhs` < `cmp_rhs`) compared unsigned.
  - No other kind asserts `carry_wr`.
- R9: Kind 13 asserts `cnt_wr` with `cnt_val` = `cnt_in` - 1, so 0 becomes 0xFF. It is taken when `cnt_val` != 0, and it writes no carry.
- R10: A branch that is not taken has `taken`=0 and `target_pc` = `seq_pc`. Kind 0 and the unused kinds 14 and 15 are never taken.
- R11: Each request with `in_valid`=1 produces its results one clock later with `out_valid`=1.
  - While `out_valid`=0, the outputs `taken`, `carry_wr`, `bit_clr` and `cnt_wr` are all 0.
  - Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| kind | input | 4 | Branch kind code |
| seq_pc | input | 16 | Address of the next sequential instruction |
| page_sel | input | 3 | Upper three bits of the in-page address field |
| opa | input | 8 | First operand byte (in-page low byte, or long-form high byte) |
| opb | input | 8 | Second operand byte (long-form low byte) |
| rel_off | input | 8 | Signed relative offset |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| carry_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Value of the addressed bit |
| cmp_lhs | input | 8 | First compare operand |
| cmp_rhs | input | 8 | Second compare operand |
| cnt_in | input | 8 | Loop counter before decrement |
| out_valid | output | 1 | Result valid |
| target_pc | output | 16 | Next program counter |
| taken | output | 1 | Branch taken |
| carry_wr | output | 1 | Carry write strobe |
| carry_val | output | 1 | Carry value to write |
| bit_clr | output | 1 | Clear the addressed bit |
| cnt_wr | output | 1 | Counter write strobe |
| cnt_val | output | 8 | Decremented counter value |

## Verification
The bench covers the wrap corners of each address form.

**Relative form.** It tries offsets of -128 and +127 from addresses near 0x0000 and 0xFFFF. A design that sign-extends wrongly would land 256 bytes away from the correct target.

**Page-absolute form.** It uses addresses at 2K boundaries. A design that takes the page from the wrong address or splices the wrong field would jump into another page.

**Indirect form.** It sums a data pointer of 0xFFFF with a nonzero accumulator. A design that treats the accumulator as signed, or keeps a carry-out bit, would give the wrong target.

**Conditional kinds.** The loop branch is run with counter values 1 and 0. The compare branch is run with equal operands and with 0xFF against 0x00. A design with an off-by-one test or a signed compare would branch the wrong way or write the wrong carry. Random requests with a fixed seed cover all sixteen kind codes against a bench model.

// File: rtl/ftu_pkg.sv
package ftu_pkg;

   localparam int KIND_W = 4;

   typedef enum logic [KIND_W-1:0] {
      K_SEQ    = 4'd0,
      K_PAGE   = 4'd1,
      K_LONG   = 4'd2,
      K_REL    = 4'd3,
      K_IND    = 4'd4,
      K_CSET   = 4'd5,
      K_CCLR   = 4'd6,
      K_AZERO  = 4'd7,
      K_ANZ    = 4'd8,
      K_BSET   = 4'd9,
      K_BCLR   = 4'd10,
      K_BTCLR  = 4'd11,
      K_CMPNE  = 4'd12,
      K_DECNZ  = 4'd13
   } kind_e;

   typedef enum logic [2:0] {
      TS_SEQ  = 3'd0,
      TS_PAGE = 3'd1,
      TS_LONG = 3'd2,
      TS_REL  = 3'd3,
      TS_IND  = 3'd4
   } tsel_e;

endpackage

// File: rtl/ftu_cond_eval.sv
module ftu_cond_eval
   import ftu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [KIND_W-1:0] kind,
   input  logic              carry_in,
   input  logic              bit_in,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] cmp_lhs,
   input  logic [DATA_W-1:0] cmp_rhs,
   input  logic [DATA_W-1:0] cnt_in,
   output logic              taken,
   output tsel_e             tsel,
   output logic              carry_wr,
   output logic              carry_val,
   output logic              bit_clr,
   output logic              cnt_wr,
   output logic [DATA_W-1:0] cnt_val
);

   logic [DATA_W-1:0] dec_val;
   logic              acc_zero;
   logic              ops_differ;
   logic              lhs_below;

   assign dec_val    = cnt_in - DATA_W'(1);
   assign acc_zero   = (acc == '0);
   assign ops_differ = (cmp_lhs != cmp_rhs);
   assign lhs_below  = (cmp_lhs < cmp_rhs);

   always_comb begin
      taken     = 1'b0;
      tsel      = TS_REL;
      carry_wr  = 1'b0;
      carry_val = 1'b0;
      bit_clr   = 1'b0;
      cnt_wr    = 1'b0;
      cnt_val   = dec_val;
      case (kind)
         K_PAGE:  begin taken = 1'b1; tsel = TS_PAGE; end
         K_LONG:  begin taken = 1'b1; tsel = TS_LONG; end
         K_REL:   taken = 1'b1;
         K_IND:   begin taken = 1'b1; tsel = TS_IND; end
         K_CSET:  taken = carry_in;
         K_CCLR:  taken = ~carry_in;
         K_AZERO: taken = acc_zero;
         K_ANZ:   taken = ~acc_zero;
         K_BSET:  taken = bit_in;
         K_BCLR:  taken = ~bit_in;
         K_BTCLR: begin taken = bit_in; bit_clr = bit_in; end
         K_CMPNE: begin
            taken     = ops_differ;
            carry_wr  = 1'b1;
            carry_val = lhs_below;
         end
         K_DECNZ: begin
            taken  = (dec_val != '0);
            cnt_wr = 1'b1;
         end
         default: begin taken = 1'b0; tsel = TS_SEQ; end
      endcase
   end

endmodule

// File: rtl/ftu_addr_calc.sv
module ftu_addr_calc
   import ftu_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 11
) (
   input  tsel_e                     tsel,
   input  logic                      taken,
   input  logic [ADDR_W-1:0]         seq_pc,
   input  logic [PAGE_W-DATA_W-1:0]  page_sel,
   input  logic [DATA_W-1:0]         opa,
   input  logic [DATA_W-1:0]         opb,
   input  logic [DATA_W-1:0]         rel_off,
   input  logic [DATA_W-1:0]         acc,
   input  logic [ADDR_W-1:0]         dptr,
   output logic [ADDR_W-1:0]         pc_out
);

   localparam int HI_W  = ADDR_W - PAGE_W;
   localparam int EXT_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] page_tgt;
   logic [ADDR_W-1:0] long_tgt;
   logic [ADDR_W-1:0] rel_tgt;
   logic [ADDR_W-1:0] ind_tgt;

   assign page_tgt = {seq_pc[ADDR_W-1 -: HI_W], page_sel, opa};
   assign long_tgt = {opa, opb};
   assign rel_tgt  = seq_pc + {{EXT_W{rel_off[DATA_W-1]}}, rel_off};
   assign ind_tgt  = dptr + {{EXT_W{1'b0}}, acc};

   always_comb begin
      pc_out = seq_pc;
      if (taken) begin
         case (tsel)
            TS_PAGE: pc_out = page_tgt;
            TS_LONG: pc_out = long_tgt;
            TS_REL:  pc_out = rel_tgt;
            TS_IND:  pc_out = ind_tgt;
            default: pc_out = seq_pc;
         endcase
      end
   end

endmodule

// File: rtl/ftu_out_stage.sv
module ftu_out_stage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         v_in,
   input  logic [W-1:0] d_in,
   output logic         v_out,
   output logic [W-1:0] d_out
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_out <= 1'b0;
               d_out <= '0;
            end else begin
               v_out <= v_in;
               d_out <= d_in;
            end
         end
      end else begin : g_bypass
         assign v_out = v_in;
         assign d_out = d_in;
      end
   endgenerate

endmodule

// File: rtl/flow_target_unit.sv
module flow_target_unit
   import ftu_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int PAGE_W  = 11,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [3:0]               kind,
   input  logic [ADDR_W-1:0]        seq_pc,
   input  logic [PAGE_W-DATA_W-1:0] page_sel,
   input  logic [DATA_W-1:0]        opa,
   input  logic [DATA_W-1:0]        opb,
   input  logic [DATA_W-1:0]        rel_off,
   input  logic [DATA_W-1:0]        acc,
   input  logic [ADDR_W-1:0]        dptr,
   input  logic                     carry_in,
   input  logic                     bit_in,
   input  logic [DATA_W-1:0]        cmp_lhs,
   input  logic [DATA_W-1:0]        cmp_rhs,
   input  logic [DATA_W-1:0]        cnt_in,
   output logic                     out_valid,
   output logic [ADDR_W-1:0]        target_pc,
   output logic                     taken,
   output logic                     carry_wr,
   output logic                     carry_val,
   output logic                     bit_clr,
   output logic                     cnt_wr,
   output logic [DATA_W-1:0]        cnt_val
);

   localparam int PAY_W = ADDR_W + DATA_W + 5;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_long
         $error("flow_target_unit: ADDR_W must be twice DATA_W for the long form");
      end
      if (PAGE_W <= DATA_W || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("flow_target_unit: PAGE_W must lie between DATA_W and ADDR_W");
      end
      if (KIND_W != 4) begin : g_bad_kind
         $error("flow_target_unit: kind code width mismatch");
      end
   endgenerate

   logic              c_taken;
   tsel_e             c_tsel;
   logic              c_carry_wr;
   logic              c_carry_val;
   logic              c_bit_clr;
   logic              c_cnt_wr;
   logic [DATA_W-1:0] c_cnt_val;
   logic [ADDR_W-1:0] c_pc;
   logic [PAY_W-1:0]  pay_in;
   logic [PAY_W-1:0]  pay_out;

   ftu_cond_eval #(.DATA_W(DATA_W)) u_cond (
      .kind      (kind),
      .carry_in  (carry_in),
      .bit_in    (bit_in),
      .acc       (acc),
      .cmp_lhs   (cmp_lhs),
      .cmp_rhs   (cmp_rhs),
      .cnt_in    (cnt_in),
      .taken     (c_taken),
      .tsel      (c_tsel),
      .carry_wr  (c_carry_wr),
      .carry_val (c_carry_val),
      .bit_clr   (c_bit_clr),
      .cnt_wr    (c_cnt_wr),
      .cnt_val   (c_cnt_val)
   );

   ftu_addr_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_addr (
      .tsel     (c_tsel),
      .taken    (c_taken),
      .seq_pc   (seq_pc),
      .page_sel (page_sel),
      .opa      (opa),
      .opb      (opb),
      .rel_off  (rel_off),
      .acc      (acc),
      .dptr     (dptr),
      .pc_out   (c_pc)
   );

   assign pay_in = {c_taken & in_valid, c_carry_wr & in_valid, c_carry_val,
                    c_bit_clr & in_valid, c_cnt_wr & in_valid, c_cnt_val, c_pc};

   ftu_out_stage #(.W(PAY_W), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (in_valid),
      .d_in  (pay_in),
      .v_out (out_valid),
      .d_out (pay_out)
   );

   assign {taken, carry_wr, carry_val, bit_clr, cnt_wr, cnt_val, target_pc} = pay_out;

   generate
      if (REG_OUT) begin : g_chk
         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> !(taken || carry_wr || bit_clr || cnt_wr)); // R11
         AST_SEQ_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !taken) |-> (target_pc == $past(seq_pc))); // R10
         AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(kind) == 4'(K_LONG)) |-> (target_pc == {$past(opa), $past(opb)})); // R2
         AST_CARRY_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
            carry_wr |-> ($past(kind) == 4'(K_CMPNE))); // R8
         AST_CLEAR_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
            bit_clr |-> (taken && $past(kind) == 4'(K_BTCLR))); // R7
         AST_LOOP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_wr && taken) |-> (cnt_val != '0)); // R9
         AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(kind) == 4'(K_PAGE))
               |-> (target_pc[ADDR_W-1:PAGE_W] == $past(seq_pc[ADDR_W-1:PAGE_W]))); // R1
      end
   endgenerate

endmodule

// File: tb/sim_flow_target_unit.sv
module sim_flow_target_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  kind = '0;
   logic [15:0] seq_pc = '0;
   logic [2:0]  page_sel = '0;
   logic [7:0]  opa = '0, opb = '0, rel_off = '0, acc = '0;
   logic [15:0] dptr = '0;
   logic        carry_in = 1'b0, bit_in = 1'b0;
   logic [7:0]  cmp_lhs = '0, cmp_rhs = '0, cnt_in = '0;
   logic        out_valid, taken, carry_wr, carry_val, bit_clr, cnt_wr;
   logic [15:0] target_pc;
   logic [7:0]  cnt_val;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flow_target_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind), .seq_pc(seq_pc),
      .page_sel(page_sel), .opa(opa), .opb(opb), .rel_off(rel_off), .acc(acc),
      .dptr(dptr), .carry_in(carry_in), .bit_in(bit_in), .cmp_lhs(cmp_lhs),
      .cmp_rhs(cmp_rhs), .cnt_in(cnt_in), .out_valid(out_valid), .target_pc(target_pc),
      .taken(taken), .carry_wr(carry_wr), .carry_val(carry_val), .bit_clr(bit_clr),
      .cnt_wr(cnt_wr), .cnt_val(cnt_val)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] k);
      case (k)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5, 4'd6, 4'd7, 4'd8: return "R5";
         4'd9, 4'd10: return "R6";
         4'd11: return "R7";
         4'd12: return "R8";
         4'd13: return "R9";
         default: return "R10";
      endcase
   endfunction

   // Bench model, written from the requirements
   task automatic model(output logic e_tk, output logic [15:0] e_pc, output logic e_cw,
                        output logic e_cv, output logic e_bc, output logic e_nw,
                        output logic [7:0] e_nv);
      logic [15:0] rel_t;
      rel_t = seq_pc + {{8{rel_off[7]}}, rel_off};
      e_cw = 0; e_cv = 0; e_bc = 0; e_nw = 0; e_nv = cnt_in - 8'd1;
      e_tk = 0; e_pc = seq_pc;
      case (kind)
         4'd1:  begin e_tk = 1; e_pc = {seq_pc[15:11], page_sel, opa}; end
         4'd2:  begin e_tk = 1; e_pc = {opa, opb}; end
         4'd3:  begin e_tk = 1; e_pc = rel_t; end
         4'd4:  begin e_tk = 1; e_pc = dptr + {8'd0, acc}; end
         4'd5:  e_tk = carry_in;
         4'd6:  e_tk = !carry_in;
         4'd7:  e_tk = (acc == 0);
         4'd8:  e_tk = (acc != 0);
         4'd9:  e_tk = bit_in;
         4'd10: e_tk = !bit_in;
         4'd11: begin e_tk = bit_in; e_bc = bit_in; end
         4'd12: begin e_tk = (cmp_lhs != cmp_rhs); e_cw = 1; e_cv = (cmp_lhs < cmp_rhs); end
         4'd13: begin e_nw = 1; e_tk = (e_nv != 0); end
         default: e_tk = 0;
      endcase
      if (e_tk && kind >= 4'd5 && kind <= 4'd13) e_pc = rel_t;
   endtask

   task automatic run_op;
      logic e_tk, e_cw, e_cv, e_bc, e_nw;
      logic [15:0] e_pc;
      logic [7:0] e_nv;
      string t;
      model(e_tk, e_pc, e_cw, e_cv, e_bc, e_nw, e_nv);
      t = tag_of(kind);
      in_valid = 1'b1;
      @(posedge clk);
      #1;
      chk(out_valid == 1'b1, "R11", "out_valid", 32'(out_valid), 32'd1);
      chk(taken == e_tk, t, "taken", 32'(taken), 32'(e_tk));
      chk(target_pc == e_pc, t, "target_pc", 32'(target_pc), 32'(e_pc));
      chk(carry_wr == e_cw, "R8", "carry_wr", 32'(carry_wr), 32'(e_cw));
      if (e_cw) chk(carry_val == e_cv, "R8", "carry_val", 32'(carry_val), 32'(e_cv));
      chk(bit_clr == e_bc, (kind == 4'd9 || kind == 4'd10) ? "R6" : "R7", "bit_clr",
          32'(bit_clr), 32'(e_bc));
      chk(cnt_wr == e_nw, "R9", "cnt_wr", 32'(cnt_wr), 32'(e_nw));
      if (e_nw) chk(cnt_val == e_nv, "R9", "cnt_val", 32'(cnt_val), 32'(e_nv));
      @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(out_valid == 0 && taken == 0 && target_pc == 0 && cnt_wr == 0 && carry_wr == 0,
          "R11", "reset outputs", {out_valid, taken, carry_wr, cnt_wr, target_pc}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: page boundaries
      kind = 4'd1; seq_pc = 16'hF800; page_sel = 3'd7; opa = 8'hFF; run_op();
      kind = 4'd1; seq_pc = 16'h07FF; page_sel = 3'd0; opa = 8'h00; run_op();
      // R2
      kind = 4'd2; opa = 8'hAB; opb = 8'hCD; run_op();
      // R3: offset extremes with wrap
      kind = 4'd3; seq_pc = 16'h0005; rel_off = 8'h80; run_op();
      kind = 4'd3; seq_pc = 16'hFFFF; rel_off = 8'h7F; run_op();
      // R4: wrap of indirect sum
      kind = 4'd4; dptr = 16'hFFFF; acc = 8'h01; run_op();
      kind = 4'd4; dptr = 16'h1000; acc = 8'hFF; run_op();
      // R5
      kind = 4'd5; carry_in = 1; seq_pc = 16'h0100; rel_off = 8'hFE; run_op();
      kind = 4'd6; carry_in = 1; run_op();
      kind = 4'd7; acc = 8'h00; run_op();
      kind = 4'd8; acc = 8'h00; run_op();
      // R6, R7
      kind = 4'd9; bit_in = 1; run_op();
      kind = 4'd10; bit_in = 1; run_op();
      kind = 4'd11; bit_in = 1; run_op();
      kind = 4'd11; bit_in = 0; run_op();
      // R8: equal, below, unsigned top
      kind = 4'd12; cmp_lhs = 8'h42; cmp_rhs = 8'h42; run_op();
      kind = 4'd12; cmp_lhs = 8'h03; cmp_rhs = 8'h05; run_op();
      kind = 4'd12; cmp_lhs = 8'hFF; cmp_rhs = 8'h00; run_op();
      // R9: counter 1 and 0
      kind = 4'd13; cnt_in = 8'h01; run_op();
      kind = 4'd13; cnt_in = 8'h00; run_op();
      // R10: sequential and unused codes
      kind = 4'd0; run_op();
      kind = 4'd15; run_op();
      // R11: idle cycle
      in_valid = 1'b0; kind = 4'd11; bit_in = 1;
      @(posedge clk); #1;
      chk(out_valid == 0 && taken == 0 && bit_clr == 0, "R11", "idle quiet",
          {out_valid, taken, bit_clr}, 32'd0);
      @(negedge clk);

      for (int i = 0; i < 400; i++) begin
         kind     = 4'($urandom_range(0, 15));
         seq_pc   = 16'($urandom);
         page_sel = 3'($urandom);
         opa      = 8'($urandom);
         opb      = 8'($urandom);
         rel_off  = 8'($urandom);
         acc      = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
         dptr     = 16'($urandom);
         carry_in = 1'($urandom);
         bit_in   = 1'($urandom);
         cmp_lhs  = 8'($urandom);
         cmp_rhs  = ($urandom_range(0, 3) == 0) ? cmp_lhs : 8'($urandom);
         cnt_in   = ($urandom_range(0, 3) == 0) ? 8'h01 : 8'($urandom);
         run_op();
      end
      finish_run();
   end

endmodule